// File: doc/BRIEF.md
# LIN Sync Field Duration Meter

This block measures how long a received LIN synchronization byte lasts, counted in periods of the local channel clock. That clock should run at 16 times the bit rate. A companion unit detects the break and sends a one-cycle strobe. After that strobe the meter watches the receive line through a two-flop synchronizer. It starts timing at the first falling edge it sees. It stops at the fifth falling edge, which is the last one in the 0x55 pattern (start bit low, data sent LSB first). Those two edges are eight bit periods apart.

When the closing edge arrives, the block produces several outputs. It gives a one-cycle done pulse and latches the 8-bit count. It also latches an in-range flag and two direction flags. Software or a resynchronization unit uses them to decide how to adjust the local clock divider. A count of 128 means the clocks match. A lower count means the local clock is slow, so the divider should be decreased. A higher count means it is fast, so the divider should be increased. The accepted window, 106 to 152, allows for a small master error combined with a large slave error.

Top module: `lin_sync_meter`

## Requirements
- R1: After reset, sync_count is 0 and meas_done, count_ok, clk_slow and clk_fast are all 0.
- R2: Timing starts only after a brk_seen strobe, at the next falling edge of the synchronized rx line. Falling edges with no preceding strobe produce no meas_done.
- R3: The count equals the number of clock cycles between the first and the fifth falling edge of rx. meas_done is high for exactly one cycle, three clock edges after the closing falling edge reaches rx_in (two synchronizer stages plus one output register).
- R4: sync_count and the flags change only in a cycle where meas_done is high. Otherwise they hold their values.
- R5: count_ok is 1 exactly when the latched count lies in the inclusive range 106 to 152.
- R6: clk_slow is 1 when the latched count is below 128. clk_fast is 1 when it is above 128. Neither is set at exactly 128.
- R7: The count saturates at 255 and does not wrap. A saturated count is reported with count_ok at 0.
- R8: A brk_seen strobe during a measurement abandons that measurement and re-arms the meter. If the strobe falls in the same cycle as the closing edge is detected, the strobe wins: no meas_done, and the next frame is measured without a further strobe.
- R9: After meas_done the meter is idle, and further falling edges are ignored until the next brk_seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock, nominally 16x bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_seen | input | 1 | One-cycle strobe: break detected, arm the meter |
| rx_in | input | 1 | Asynchronous LIN receive line, idle high |
| sync_count | output | 8 | Latched sync field duration in clock cycles |
| meas_done | output | 1 | One-cycle pulse when a new count is latched |
| count_ok | output | 1 | Latched count within the accepted window |
| clk_slow | output | 1 | Latched count below nominal: decrease divider |
| clk_fast | output | 1 | Latched count above nominal: increase divider |

## Verification
The critical collision is a break strobe arriving in the same cycle as the closing falling edge, because re-arming and completing a measurement compete there. The bench places the strobe exactly in the detection cycle, three clocks after it drives the closing edge. It expects no done pulse. It then sends a second frame without a new strobe and expects a normal measurement from it. A second, milder overlap is a measurement that closes on a saturated counter. There, the bench expects the count to stick at 255 with the in-range flag clear.

// File: rtl/lin_sync_meter.sv
module lin_sync_meter #(
  parameter int CNT_W       = 8,
  parameter int BIT_CLKS    = 16,
  parameter int SYNC_BITS   = 8,
  parameter int OK_MIN      = 106,
  parameter int OK_MAX      = 152,
  parameter int CLOSE_EDGES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brk_seen,
  input  logic             rx_in,
  output logic [CNT_W-1:0] sync_count,
  output logic             meas_done,
  output logic             count_ok,
  output logic             clk_slow,
  output logic             clk_fast
);
  localparam int EW = $clog2(CLOSE_EDGES + 1);
  localparam logic [CNT_W-1:0] CMAX    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] NOMINAL = CNT_W'(BIT_CLKS * SYNC_BITS);
  localparam logic [CNT_W-1:0] LO      = CNT_W'(OK_MIN);
  localparam logic [CNT_W-1:0] HI      = CNT_W'(OK_MAX);
  localparam logic [EW-1:0]    LAST    = EW'(CLOSE_EDGES - 1);

  logic rx_s1, rx_s2, rx_d;
  logic armed, meas;
  logic [CNT_W-1:0] run;
  logic [EW-1:0] edges;

  wire fall  = rx_d & ~rx_s2;
  wire close = meas & fall & (edges == LAST) & ~brk_seen;
  wire [CNT_W-1:0] run_inc = (run == CMAX) ? run : run + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
      rx_d  <= 1'b1;
    end else begin
      rx_s1 <= rx_in;
      rx_s2 <= rx_s1;
      rx_d  <= rx_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      meas  <= 1'b0;
      run   <= '0;
      edges <= '0;
    end else if (brk_seen) begin
      armed <= 1'b1;
      meas  <= 1'b0;
    end else if (armed && fall) begin
      armed <= 1'b0;
      meas  <= 1'b1;
      run   <= CNT_W'(1);
      edges <= '0;
    end else if (meas) begin
      run <= run_inc;
      if (fall) begin
        if (edges == LAST) meas <= 1'b0;
        else edges <= edges + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_count <= '0;
      meas_done  <= 1'b0;
      count_ok   <= 1'b0;
      clk_slow   <= 1'b0;
      clk_fast   <= 1'b0;
    end else begin
      meas_done <= close;
      if (close) begin
        sync_count <= run;
        count_ok   <= (run >= LO) && (run <= HI) && (run != CMAX);
        clk_slow   <= run < NOMINAL;
        clk_fast   <= run > NOMINAL;
      end
    end
  end
endmodule

module lin_sync_meter_chk #(
  parameter int CNT_W  = 8,
  parameter int OK_MIN = 106,
  parameter int OK_MAX = 152
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] sync_count,
  input logic             meas_done,
  input logic             count_ok,
  input logic             clk_slow,
  input logic             clk_fast
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> !meas_done);
  a_r4_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |-> $stable(sync_count) && $stable(count_ok));
  a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done && count_ok |-> (int'(sync_count) >= OK_MIN) && (int'(sync_count) <= OK_MAX));
  a_r6_direction_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_slow && clk_fast));
  a_r7_sat_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done && (sync_count == {CNT_W{1'b1}}) |-> !count_ok);
endmodule

bind lin_sync_meter lin_sync_meter_chk #(.CNT_W(CNT_W), .OK_MIN(OK_MIN), .OK_MAX(OK_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .sync_count(sync_count), .meas_done(meas_done),
  .count_ok(count_ok), .clk_slow(clk_slow), .clk_fast(clk_fast));

// File: tb/lin_sync_meter_tb_top.sv
module lin_sync_meter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic brk_seen = 1'b0;
  logic rx_in = 1'b1;
  logic [7:0] sync_count;
  logic meas_done, count_ok, clk_slow, clk_fast;
  int vectors = 0;
  int fails = 0;
  int n_done = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lin_sync_meter dut_i (
    .clk(clk), .rst_n(rst_n), .brk_seen(brk_seen), .rx_in(rx_in),
    .sync_count(sync_count), .meas_done(meas_done), .count_ok(count_ok),
    .clk_slow(clk_slow), .clk_fast(clk_fast));

  always @(negedge clk) if (meas_done) n_done++;

  task automatic chk(input string req, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // mode 0: measurement expected; 1: break at closing edge; 2: no break, no done expected
  task automatic frame(input int a, input int b, input bit send_break, input int mode);
    int total;
    int expc;
    total = a + 7 * b;
    expc = (total > 255) ? 255 : total;
    if (send_break) begin
      @(negedge clk) brk_seen = 1'b1;
      @(negedge clk) brk_seen = 1'b0;
      repeat (3) @(negedge clk);
    end
    for (int i = 0; i < 10; i++) begin
      int len;
      len = (i == 0) ? a : b;
      rx_in = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : 1'(8'h55 >> (i - 1));
      for (int j = 0; j < len; j++) begin
        @(negedge clk);
        if (i == 8 && mode == 1 && j == 1) brk_seen = 1'b1;
        if (i == 8 && j == 2) begin
          brk_seen = 1'b0;
          if (mode == 0) begin
            chk("R3 done", int'(meas_done), 1);
            chk("R3 count", int'(sync_count), expc);
            chk("R5 ok", int'(count_ok), int'(expc >= 106 && expc <= 152));
            chk("R6 slow", int'(clk_slow), int'(expc < 128));
            chk("R6 fast", int'(clk_fast), int'(expc > 128));
            if (expc == 255) chk("R7 sat ok", int'(count_ok), 0);
          end else begin
            chk(mode == 1 ? "R8 no done" : "R2 no done", int'(meas_done), 0);
          end
        end
      end
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int d0, c0;
    repeat (3) @(negedge clk);
    chk("R1 count", int'(sync_count), 0);
    chk("R1 flags", int'({meas_done, count_ok, clk_slow, clk_fast}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2: edges before any break are ignored
    frame(16, 16, 1'b0, 2);
    chk("R2 no pulses", n_done, 0);
    // R3/R5/R6: sweep of bit lengths and start-bit skew
    for (int b = 10; b <= 20; b++)
      for (int a = b - 3; a <= b + 3; a++) frame(a, b, 1'b1, 0);
    // R5 boundaries 105,106,152,153 and nominal 128
    frame(14, 13, 1'b1, 0);
    frame(15, 13, 1'b1, 0);
    frame(19, 19, 1'b1, 0);
    frame(20, 19, 1'b1, 0);
    frame(16, 16, 1'b1, 0);
    // R7 saturation
    frame(32, 32, 1'b1, 0);
    frame(40, 40, 1'b1, 0);
    // R4/R9: after done, edges without break leave state untouched
    frame(17, 17, 1'b1, 0);
    d0 = n_done;
    c0 = int'(sync_count);
    frame(12, 12, 1'b0, 2);
    chk("R9 no done", n_done, d0);
    chk("R4 held", int'(sync_count), c0);
    // R8: break at closing edge wins and re-arms
    frame(16, 16, 1'b1, 1);
    chk("R8 held", int'(sync_count), c0);
    frame(15, 15, 1'b0, 0);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule